// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in in a single combinational pass. The operands are split into four 4-bit groups. Inside each group, every bit pair is classified: both ones create a carry, both zeros stop one, and a mixed pair hands on the carry it receives. A flat sum-of-products lookahead then forms each internal carry directly from those classifications. No carry ripples from bit to bit.

Each group condenses its four bits into one group generate flag and one group propagate flag. A second lookahead stage uses the same circuit, built from the same module. It takes the four group flag pairs and the carry-in, and forms the carry into every group and the final carry-out. The overall group generate and propagate of the whole adder are also brought out, so that several copies can be joined by a further lookahead level into a wider adder.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `opA + opB + carryIn` in the same evaluation, with no clock involved.
- R2: `carryOut` equals bit 16 of the 17-bit result of `opA + opB + carryIn`.
- R3: `groupProp` is 1 exactly when `opA ^ opB` is 0xFFFF, meaning every bit pair differs.
- R4: `groupGen` is 1 exactly when `opA + opB` overflows 16 bits with the carry-in taken as 0, whatever `carryIn` actually is.
- R5: When every bit pair differs, the carry-in passes to `carryOut` unchanged, and `sum` is 0x0000 for carry-in 1 or 0xFFFF for carry-in 0.
- R6: `carryOut` equals `groupGen | (groupProp & carryIn)` for every input, which is the relation a wider lookahead level relies on.
- R7: A bit pair of two zeros gives a carry of 0 into the next bit, and a pair of two ones gives a carry of 1, whatever carry arrives at that pair. This holds across group boundaries too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the sum |
| carryOut | output | 1 | Carry out of bit 15 |
| groupGen | output | 1 | Whole-adder generate, for cascading |
| groupProp | output | 1 | Whole-adder propagate, for cascading |

## Verification
Both polarities of the carry-in are tried with operands whose pairs all differs, such as 0xFFFF with 0 and 0xAAAA with 0x5555. This shows a true pass-through path apart from a generated carry. Sums that carry across exactly one group boundary, and operands whose bits are all ones or all zeros, test the carry into each group from the second stage separately from the carries inside a group. Operands made of zero pairs placed above carry-producing bits check that a stopped carry goes no further. A few thousand random operand pairs, compared with a 17-bit behavioural sum, cover mixed patterns, and the group flags are checked against overflow and all-differ conditions computed on their own.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Default shape of the adder: groups of four bits, four groups.
  localparam int unsigned DefGroupW = 4;
  localparam int unsigned DefNumGroups = 4;

  // Generate / propagate pair handed from a group to the level above.
  typedef struct packed {
    logic gen;
    logic prop;
  } gpPair_t;
endpackage

// File: rtl/cla_lookahead_unit.sv
// Flat lookahead over N generate/propagate inputs. The same unit serves
// inside a group (bit level) and across groups (second level).
module cla_lookahead_unit #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] genIn,
  input  logic [N-1:0] propIn,
  input  logic         carryIn,
  output logic [N:0]   carries,
  output logic         groupGen,
  output logic         groupProp
);

  // carries[i] = OR over j<i of genIn[j] & propIn[j+1..i-1], OR carryIn & propIn[0..i-1]
  always_comb begin
    for (int i = 0; i <= int'(N); i++) begin
      logic acc;
      logic prod;
      acc = 1'b0;
      for (int j = 0; j < i; j++) begin
        prod = genIn[j];
        for (int k = j + 1; k < i; k++) begin
          prod = prod & propIn[k];
        end
        acc = acc | prod;
      end
      prod = carryIn;
      for (int k = 0; k < i; k++) begin
        prod = prod & propIn[k];
      end
      carries[i] = acc | prod;
    end
  end

  // Group generate: same sum of products with no incoming carry term.
  always_comb begin
    logic accG;
    logic prodG;
    accG = 1'b0;
    for (int j = 0; j < int'(N); j++) begin
      prodG = genIn[j];
      for (int k = j + 1; k < int'(N); k++) begin
        prodG = prodG & propIn[k];
      end
      accG = accG | prodG;
    end
    groupGen = accG;
  end

  assign groupProp = &propIn;

  // Cascade relation between the exported pair and the computed carry-out.
  always_comb begin
    assert_pass_through_R5: assert (!groupProp || (carries[N] == carryIn))
      else $error("all-propagate unit did not pass its carry");
    assert_cascade_rel_R6: assert (carries[N] == (groupGen | (groupProp & carryIn)))
      else $error("carry-out disagrees with exported generate/propagate");
  end

endmodule

// File: rtl/cla_group.sv
// One group of GROUP_W bits: per-bit classification, local lookahead, sum.
module cla_group
  import cla_pkg::*;
#(
  parameter int unsigned GROUP_W = DefGroupW
) (
  input  logic [GROUP_W-1:0] grpA,
  input  logic [GROUP_W-1:0] grpB,
  input  logic               grpCin,
  output logic [GROUP_W-1:0] grpSum,
  output logic               grpCout,
  output gpPair_t            grpFlags
);

  logic [GROUP_W-1:0] bitGen;
  logic [GROUP_W-1:0] bitProp;
  logic [GROUP_W:0]   bitCarry;
  logic               unitGen;
  logic               unitProp;

  assign bitGen  = grpA & grpB;
  assign bitProp = grpA ^ grpB;

  cla_lookahead_unit #(.N(GROUP_W)) bitLevel_i (
    .genIn    (bitGen),
    .propIn   (bitProp),
    .carryIn  (grpCin),
    .carries  (bitCarry),
    .groupGen (unitGen),
    .groupProp(unitProp)
  );

  assign grpSum        = bitProp ^ bitCarry[GROUP_W-1:0];
  assign grpCout       = bitCarry[GROUP_W];
  assign grpFlags.gen  = unitGen;
  assign grpFlags.prop = unitProp;

  // A zero pair stops the carry; a ones pair always produces one.
  for (genvar b = 0; b < int'(GROUP_W); b++) begin : g_bitChk
    always_comb begin
      assert_kill_bit_R7: assert ((grpA[b] | grpB[b]) || !bitCarry[b+1])
        else $error("carry escaped a zero bit pair");
      assert_gen_bit_R7: assert (!(grpA[b] & grpB[b]) || bitCarry[b+1])
        else $error("ones bit pair did not produce a carry");
    end
  end

endmodule

// File: rtl/cla_adder.sv
// Top: GROUP_W x NUM_GROUPS bit adder with a second lookahead level.
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned GROUP_W    = DefGroupW,
  parameter int unsigned NUM_GROUPS = DefNumGroups,
  localparam int unsigned WIDTH     = GROUP_W * NUM_GROUPS
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             groupGen,
  output logic             groupProp
);

  gpPair_t [NUM_GROUPS-1:0] grpFlags;
  logic    [NUM_GROUPS-1:0] grpGenVec;
  logic    [NUM_GROUPS-1:0] grpPropVec;
  logic    [NUM_GROUPS-1:0] grpLocalCout;
  logic    [NUM_GROUPS:0]   grpCarry;

  for (genvar g = 0; g < int'(NUM_GROUPS); g++) begin : g_group
    cla_group #(.GROUP_W(GROUP_W)) group_i (
      .grpA    (opA[g*GROUP_W +: GROUP_W]),
      .grpB    (opB[g*GROUP_W +: GROUP_W]),
      .grpCin  (grpCarry[g]),
      .grpSum  (sum[g*GROUP_W +: GROUP_W]),
      .grpCout (grpLocalCout[g]),
      .grpFlags(grpFlags[g])
    );
    assign grpGenVec[g]  = grpFlags[g].gen;
    assign grpPropVec[g] = grpFlags[g].prop;

    // The group's own carry-out must agree with the second level's view.
    always_comb begin
      assert_group_carry_R2: assert (grpLocalCout[g] == grpCarry[g+1])
        else $error("group carry-out disagrees with second-level carry");
    end
  end

  cla_lookahead_unit #(.N(NUM_GROUPS)) groupLevel_i (
    .genIn    (grpGenVec),
    .propIn   (grpPropVec),
    .carryIn  (carryIn),
    .carries  (grpCarry),
    .groupGen (groupGen),
    .groupProp(groupProp)
  );

  assign carryOut = grpCarry[NUM_GROUPS];

  always_comb begin
    assert_prop_all_differ_R3: assert (groupProp == (&(opA ^ opB)))
      else $error("exported propagate wrong");
  end

endmodule

// File: tb/cla_adder_tb_top.sv
module cla_adder_tb_top;

  localparam int W = 16;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cin;
    logic [W-1:0] expSum;
    logic         expCout;
    logic         expGen;
    logic         expProp;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sum;
  logic         carryOut;
  logic         groupGen;
  logic         groupProp;

  cla_adder dut_i (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sum(sum), .carryOut(carryOut),
    .groupGen(groupGen), .groupProp(groupProp)
  );

  item_t expQ[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    driveDone = 1'b0;
  bit    finished = 1'b0;

  task automatic check(string req, string what, int actual, int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h (a=%h b=%h cin=%0d)",
               req, what, actual, expected, opA, opB, carryIn);
    end
  endtask

  // Driver: applies one vector per cycle and queues its expectation.
  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic cin, string tag);
    item_t it;
    logic [W:0] full;
    logic [W:0] noCin;
    @(posedge clk);
    opA = a; opB = b; carryIn = cin;
    full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    noCin = {1'b0, a} + {1'b0, b};
    it.a = a; it.b = b; it.cin = cin;
    it.expSum  = full[W-1:0];
    it.expCout = full[W];
    it.expGen  = noCin[W];
    it.expProp = ((a ^ b) == {W{1'b1}});
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compares away from the driving edge.
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        check({"R1 ", it.tag}, "sum", int'(sum), int'(it.expSum));
        check({"R2 ", it.tag}, "carryOut", int'(carryOut), int'(it.expCout));
        check({"R3 ", it.tag}, "groupProp", int'(groupProp), int'(it.expProp));
        check({"R4 ", it.tag}, "groupGen", int'(groupGen), int'(it.expGen));
        check({"R6 ", it.tag}, "cascade", int'(carryOut),
              int'(it.expGen | (it.expProp & it.cin)));
      end
    end
  end

  initial begin
    // Zero inputs give an all-zero result (initial state).
    drive(16'h0000, 16'h0000, 1'b0, "zero");
    // R5: all pairs differ, carry-in passes straight through.
    drive(16'hFFFF, 16'h0000, 1'b1, "R5 ffff+0+1");
    drive(16'hFFFF, 16'h0000, 1'b0, "R5 ffff+0+0");
    drive(16'hAAAA, 16'h5555, 1'b1, "R5 aaaa+5555+1");
    drive(16'h5555, 16'hAAAA, 1'b0, "R5 5555+aaaa+0");
    // Generated carry independent of carry-in.
    drive(16'hFFFF, 16'hFFFF, 1'b1, "gen ffff+ffff+1");
    drive(16'h8000, 16'h8000, 1'b0, "gen msb pair");
    // R7: group-boundary carries and zero pairs stopping carries.
    for (int g = 0; g < 4; g++) begin
      drive(16'((32'h1 << (4*g + 4)) - 1), 16'h0001, 1'b0, "R7 boundary");
    end
    drive(16'h00FF, 16'h0001, 1'b0, "R7 stop above byte");
    drive(16'h0F0F, 16'h0F0F, 1'b1, "R7 ones pairs");
    drive(16'h0000, 16'h0000, 1'b1, "R7 kill all cin1");
    // Random vectors.
    for (int i = 0; i < 3000; i++) begin
      drive(16'($urandom), 16'($urandom), 1'($urandom), "random");
    end
    driveDone = 1'b1;
  end

  // R5 explicit values: captured straight from ports.
  initial begin
    wait (driveDone);
    @(posedge clk); opA = 16'hFFFF; opB = 16'h0000; carryIn = 1'b1;
    @(negedge clk);
    check("R5", "sum ffff+0+1", int'(sum), 0);
    check("R5", "cout ffff+0+1", int'(carryOut), 1);
    @(posedge clk); carryIn = 1'b0;
    @(negedge clk);
    check("R5", "sum ffff+0+0", int'(sum), 16'hFFFF);
    check("R5", "cout ffff+0+0", int'(carryOut), 0);
    wait (expQ.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule